// File: doc/BRIEF.md
# Control Endpoint Status and Interrupt Logic

This block handles the status side of endpoint zero inside a USB device controller. It listens to a simple stream of strobes from the packet engine, one per cycle at most: setup byte, data byte, end of packet and error. An 8-byte setup packet is collected into a shadow buffer. Only a packet that arrives complete and clean is copied into the setup registers that firmware reads. In the data stage of a control write, each data packet is written into a small receive FIFO. If it ends cleanly, the block raises a packet-ready flag and reports the byte count.

Firmware works through a 4-bit register port. It reads the setup bytes, the status, the enables, the count and the FIFO. It clears status bits by writing ones. A single interrupt line is driven from a register that holds the OR of each enabled status bit.

The setup-ready flag protects itself against a late clear. Suppose a second setup packet lands while the flag is still set. The next write-one clear is then used up and the flag stays set. Firmware must read the new setup bytes and clear the flag a second time.

Top module: `ep0_ctl_status`

## Requirements
- R1: A setup packet of exactly 8 setup bytes followed by end of packet is copied into the setup registers at addresses 0..7 (byte 0 at address 0). Status bit 2 (setup ready) at address 8 reads 1 from the cycle after the end-of-packet strobe.
- R2: A setup packet with fewer or more than 8 bytes, or one that ends with the error strobe, leaves the setup registers and setup ready unchanged.
- R3: Writing 1 to status bit 2 clears setup ready, with one exception. If a further valid setup packet completed while setup ready was already 1, the first such write leaves the flag at 1, and only a later write clears it.
- R4: A valid setup packet whose byte 0 has bit 7 equal to 0 enters the data stage of a control write. One with bit 7 equal to 1 leaves the data stage. Outside the data stage, data packets never set receive ready.
- R5: In the data stage, a data packet of 0 to MAX_PKT bytes that ends with end of packet sets status bit 0 (receive ready). The count register at address 10 then holds its byte count. While receive ready is 1, further data packets change neither the count nor the stored bytes.
- R6: A data packet that ends with the error strobe, or that carries more than MAX_PKT bytes, is discarded. It leaves receive ready and the count unchanged.
- R7: The enable register at address 9 uses bit 1 for setup ready and bit 6 for receive ready. irq is a register holding the OR of the enabled status bits. It rises and falls one cycle after the status changes.
- R8: Writing 0 to a status bit has no effect.
- R9: Each read of address 11 returns the next stored byte of the received packet in arrival order. Reads beyond the count return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pk_setup | input | 1 | Setup byte strobe |
| pk_data | input | 1 | Data byte strobe |
| pk_byte | input | 8 | Byte that goes with a byte strobe |
| pk_eop | input | 1 | End of packet, clean finish |
| pk_err | input | 1 | Packet finished with an error |
| cpu_addr | input | 4 | Register address |
| cpu_wr | input | 1 | Register write strobe |
| cpu_wdata | input | 8 | Write data |
| cpu_rd | input | 1 | Read strobe; at address 11 it pops the FIFO |
| cpu_rdata | output | 8 | Read data, combinational from cpu_addr |
| irq | output | 1 | Registered interrupt request |

## Verification
On every cycle the assertions check four things. irq follows the enabled status bits with one cycle of delay. The byte count never exceeds MAX_PKT. Receive ready and its count hold until a write-one clear. A clear that arrives while a newer setup is pending leaves setup ready set. The bench scenarios cover the cases that involve data content and sequencing: setup bytes landing in the right registers, rejection of short, long and errored setup packets, the effect of the direction bit on whether data is accepted, the order in which FIFO bytes come out, and data packets that are dropped for overflow or error.

// File: rtl/ep0_ctl_status.sv
module ep0_ctl_status #(
  parameter int MAX_PKT = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pk_setup,
  input  logic       pk_data,
  input  logic [7:0] pk_byte,
  input  logic       pk_eop,
  input  logic       pk_err,
  input  logic [3:0] cpu_addr,
  input  logic       cpu_wr,
  input  logic [7:0] cpu_wdata,
  input  logic       cpu_rd,
  output logic [7:0] cpu_rdata,
  output logic       irq
);
  localparam int CW = $clog2(MAX_PKT + 1);
  localparam int PW = (MAX_PKT > 1) ? $clog2(MAX_PKT) : 1;
  localparam logic [CW-1:0] FULL = CW'(MAX_PKT);

  logic [7:0] sreg [8];
  logic [7:0] shad [8];
  logic [7:0] fifo [MAX_PKT];
  logic [3:0] scnt;
  logic in_setup, s_bad;
  logic setup_rdy, setup_again, rx_rdy, dstage;
  logic en_s, en_r;
  logic d_act, d_bad;
  logic [CW-1:0] wcnt, rx_cnt, rptr;

  wire wr_stat  = cpu_wr && cpu_addr == 4'd8;
  wire clr_s    = wr_stat && cpu_wdata[2];
  wire clr_r    = wr_stat && cpu_wdata[0];
  wire d_accept = dstage && !rx_rdy;
  wire s_done   = pk_eop && in_setup && !s_bad && scnt == 4'd8;
  wire pkt_end  = pk_eop || pk_err;
  wire d_clean  = d_act ? !d_bad : d_accept;
  wire d_done   = pk_eop && !in_setup && d_accept && d_clean;
  wire [CW-1:0] d_len = d_act ? wcnt : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      scnt <= '0; in_setup <= 1'b0; s_bad <= 1'b0;
      for (int i = 0; i < 8; i++) shad[i] <= '0;
    end else if (pk_setup) begin
      if (!in_setup) begin
        in_setup <= 1'b1; s_bad <= 1'b0; shad[0] <= pk_byte; scnt <= 4'd1;
      end else if (scnt == 4'd8) begin
        s_bad <= 1'b1;
      end else begin
        shad[scnt[2:0]] <= pk_byte; scnt <= scnt + 4'd1;
      end
    end else if (pkt_end) begin
      in_setup <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 8; i++) sreg[i] <= '0;
      setup_rdy <= 1'b0; setup_again <= 1'b0; dstage <= 1'b0;
    end else if (s_done) begin
      for (int i = 0; i < 8; i++) sreg[i] <= shad[i];
      setup_rdy <= 1'b1; setup_again <= setup_rdy; dstage <= !shad[0][7];
    end else if (clr_s) begin
      if (setup_again) setup_again <= 1'b0;
      else setup_rdy <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      d_act <= 1'b0; d_bad <= 1'b0; wcnt <= '0;
      for (int i = 0; i < MAX_PKT; i++) fifo[i] <= '0;
    end else if (pk_data) begin
      if (!d_act) begin
        d_act <= 1'b1; d_bad <= !d_accept; wcnt <= CW'(1);
        if (d_accept) fifo[0] <= pk_byte;
      end else if (wcnt == FULL) begin
        d_bad <= 1'b1;
      end else begin
        if (d_accept) fifo[wcnt[PW-1:0]] <= pk_byte;
        wcnt <= wcnt + CW'(1);
      end
    end else if (pkt_end) begin
      d_act <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rx_rdy <= 1'b0; rx_cnt <= '0; rptr <= '0;
    end else if (d_done) begin
      rx_rdy <= 1'b1; rx_cnt <= d_len; rptr <= '0;
    end else begin
      if (clr_r) rx_rdy <= 1'b0;
      if (cpu_rd && cpu_addr == 4'd11 && rptr < rx_cnt) rptr <= rptr + CW'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_s <= 1'b0; en_r <= 1'b0; irq <= 1'b0;
    end else begin
      if (cpu_wr && cpu_addr == 4'd9) begin
        en_s <= cpu_wdata[1]; en_r <= cpu_wdata[6];
      end
      irq <= (setup_rdy && en_s) || (rx_rdy && en_r);
    end
  end

  always_comb begin
    cpu_rdata = '0;
    case (cpu_addr)
      4'd8:  cpu_rdata = {5'b0, setup_rdy, 1'b0, rx_rdy};
      4'd9:  cpu_rdata = {1'b0, en_r, 4'b0, en_s, 1'b0};
      4'd10: cpu_rdata = 8'(rx_cnt);
      4'd11: if (rptr < rx_cnt) cpu_rdata = fifo[rptr[PW-1:0]];
      default: if (!cpu_addr[3]) cpu_rdata = sreg[cpu_addr[2:0]];
    endcase
  end
endmodule

// File: rtl/ep0_ctl_status_chk.sv
module ep0_ctl_status_chk #(
  parameter int MAX_PKT = 8,
  parameter int CW = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          setup_rdy,
  input logic          setup_again,
  input logic          rx_rdy,
  input logic          en_s,
  input logic          en_r,
  input logic          irq,
  input logic [CW-1:0] rx_cnt,
  input logic          cpu_wr,
  input logic [3:0]    cpu_addr,
  input logic [7:0]    cpu_wdata
);
  wire any_on   = (setup_rdy && en_s) || (rx_rdy && en_r);
  wire rx_clear = cpu_wr && cpu_addr == 4'd8 && cpu_wdata[0];

  p_irq_rise_r7: assert property (@(posedge clk) disable iff (!rst_n) any_on |=> irq);
  p_irq_fall_r7: assert property (@(posedge clk) disable iff (!rst_n) !any_on |=> !irq);
  p_cnt_bound_r5: assert property (@(posedge clk) disable iff (!rst_n) rx_cnt <= CW'(MAX_PKT));
  p_rx_hold_r5: assert property (@(posedge clk) disable iff (!rst_n) rx_rdy && !rx_clear |=> rx_rdy);
  p_cnt_stable_r6: assert property (@(posedge clk) disable iff (!rst_n) rx_rdy |=> $stable(rx_cnt));
  p_setup_keep_r3: assert property (@(posedge clk) disable iff (!rst_n) setup_rdy && setup_again |=> setup_rdy);
endmodule

bind ep0_ctl_status ep0_ctl_status_chk #(.MAX_PKT(MAX_PKT), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .setup_rdy(setup_rdy), .setup_again(setup_again),
  .rx_rdy(rx_rdy), .en_s(en_s), .en_r(en_r), .irq(irq), .rx_cnt(rx_cnt),
  .cpu_wr(cpu_wr), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata)
);

// File: tb/test_ep0_ctl_status.sv
module test_ep0_ctl_status;
  localparam int MP = 8;
  logic clk = 0, rst_n = 0;
  logic pk_setup = 0, pk_data = 0, pk_eop = 0, pk_err = 0, cpu_wr = 0, cpu_rd = 0;
  logic [7:0] pk_byte = 0, cpu_wdata = 0, cpu_rdata;
  logic [3:0] cpu_addr = 0;
  logic irq;
  int n_chk = 0, n_bad = 0;
  logic [7:0] exp_s [8];
  logic [7:0] pkt [MP+1];

  always #5 clk = ~clk;

  ep0_ctl_status #(.MAX_PKT(MP)) i_ep0_ctl_status (.*);

  task automatic check(string tag, int got, int exp);
    n_chk++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s got=%0h exp=%0h", tag, got, exp);
    end
  endtask

  task automatic strobe(bit s, bit d, bit e, bit r, logic [7:0] b);
    @(negedge clk);
    pk_setup = s; pk_data = d; pk_eop = e; pk_err = r; pk_byte = b;
    @(negedge clk);
    pk_setup = 0; pk_data = 0; pk_eop = 0; pk_err = 0;
  endtask

  task automatic wr(logic [3:0] a, logic [7:0] d);
    @(negedge clk);
    cpu_wr = 1; cpu_addr = a; cpu_wdata = d;
    @(negedge clk);
    cpu_wr = 0;
  endtask

  task automatic rd(logic [3:0] a, output logic [7:0] d);
    @(negedge clk);
    cpu_rd = 1; cpu_addr = a;
    #1 d = cpu_rdata;
    @(negedge clk);
    cpu_rd = 0;
  endtask

  function automatic logic [7:0] sbyte(int k, int i, logic [7:0] b0);
    return (i == 0) ? b0 : 8'(k * 16 + i * 3 + 1);
  endfunction

  task automatic setup_pkt(int k, int n, logic [7:0] b0, bit err);
    for (int i = 0; i < n; i++) strobe(1, 0, 0, 0, sbyte(k, i, b0));
    strobe(0, 0, !err, err, 0);
  endtask

  task automatic data_pkt(int n, bit err);
    for (int i = 0; i < n; i++) strobe(0, 1, 0, 0, pkt[i]);
    strobe(0, 0, !err, err, 0);
  endtask

  task automatic check_setup(string tag);
    logic [7:0] v;
    for (int i = 0; i < 8; i++) begin
      rd(4'(i), v);
      check(tag, v, exp_s[i]);
    end
  endtask

  bit done = 0;
  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_bad++; n_chk++;
      $display("FAIL watchdog got=hang exp=finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    int n;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst_n = 1;
    rd(4'd8, v);  check("R1 reset status", v, 0);
    rd(4'd10, v); check("R5 reset count", v, 0);
    check("R7 reset irq", irq, 0);

    // R1: setup capture, control write direction
    setup_pkt(1, 8, 8'h00, 0);
    for (int i = 0; i < 8; i++) exp_s[i] = sbyte(1, i, 8'h00);
    rd(4'd8, v); check("R1 setup ready", v, 8'h04);
    check_setup("R1 setup bytes");

    // R7: enables and irq timing
    wr(4'd9, 8'h42);
    rd(4'd9, v); check("R7 enable readback", v, 8'h42);
    check("R7 irq on", irq, 1);
    // R8: writing zeros has no effect
    wr(4'd8, 8'h00);
    rd(4'd8, v); check("R8 zero write", v, 8'h04);

    // R3: second setup before the clear
    setup_pkt(2, 8, 8'h00, 0);
    for (int i = 0; i < 8; i++) exp_s[i] = sbyte(2, i, 8'h00);
    wr(4'd8, 8'h04);
    rd(4'd8, v); check("R3 clear consumed", v, 8'h04);
    check("R3 irq kept", irq, 1);
    check_setup("R3 newer setup");
    @(negedge clk);
    cpu_wr = 1; cpu_addr = 4'd8; cpu_wdata = 8'h04;
    @(negedge clk);
    cpu_wr = 0;
    check("R7 irq one cycle late", irq, 1);
    @(negedge clk);
    check("R7 irq fall", irq, 0);
    rd(4'd8, v); check("R3 second clear", v, 8'h00);

    // R2: bad setup packets
    setup_pkt(3, 7, 8'h00, 0);
    rd(4'd8, v); check("R2 short setup", v, 0);
    setup_pkt(4, 9, 8'h00, 0);
    rd(4'd8, v); check("R2 long setup", v, 0);
    setup_pkt(5, 8, 8'h00, 1);
    rd(4'd8, v); check("R2 errored setup", v, 0);
    check_setup("R2 regs kept");

    // R5/R9: random data packets in data stage, irq rise timing
    for (int it = 0; it < 40; it++) begin
      n = $urandom_range(0, MP);
      for (int i = 0; i < n; i++) pkt[i] = 8'($urandom);
      for (int i = 0; i < n; i++) strobe(0, 1, 0, 0, pkt[i]);
      @(negedge clk);
      pk_eop = 1;
      @(negedge clk);
      pk_eop = 0;
      check("R7 irq before rise", irq, 0);
      @(negedge clk);
      check("R7 irq rise", irq, 1);
      rd(4'd8, v);  check("R5 rx ready", v, 8'h01);
      rd(4'd10, v); check("R5 count", v, n);
      for (int i = 0; i < n; i++) begin
        rd(4'd11, v); check("R9 fifo byte", v, pkt[i]);
      end
      rd(4'd11, v); check("R9 past end", v, 0);
      if (it == 5) begin
        // R5: packet while ready is ignored
        for (int i = 0; i < MP; i++) pkt[i] = 8'hA5;
        data_pkt(MP, 0);
        rd(4'd10, v); check("R5 ignored count", v, n);
      end
      wr(4'd8, 8'h01);
      rd(4'd8, v); check("R5 cleared", v, 0);
    end

    // R6: overflow and error
    for (int i = 0; i <= MP; i++) pkt[i] = 8'(i);
    data_pkt(MP + 1, 0);
    rd(4'd8, v); check("R6 overflow dropped", v, 0);
    data_pkt(3, 1);
    rd(4'd8, v); check("R6 error dropped", v, 0);
    data_pkt(MP, 0);
    rd(4'd10, v); check("R6 full packet after", v, MP);
    wr(4'd8, 8'h01);

    // R4: device-to-host setup leaves data stage
    setup_pkt(6, 8, 8'h80, 0);
    wr(4'd8, 8'h04);
    data_pkt(2, 0);
    rd(4'd8, v); check("R4 no data stage", v, 0);
    setup_pkt(7, 8, 8'h21, 0);
    wr(4'd8, 8'h04);
    data_pkt(2, 0);
    rd(4'd8, v); check("R4 data stage again", v, 8'h01);
    rd(4'd10, v); check("R4 count", v, 2);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule